// File: doc/BRIEF.md
# Default Control Endpoint Control/Status Register

This block holds the eight-bit control and status word for endpoint zero of a USB device controller. Firmware reaches it through a plain write port with byte data and a combinational read-back bus. An external lock input, when high, causes every software write to be dropped. The endpoint engine reports four kinds of event: a packet arrived, a transmit packet went out, a STALL handshake was issued, and the control transfer ended. The register sends back three levels to that engine: transmit-ready, stall request and last-data-packet. It also raises an interrupt pulse and a FIFO flush pulse.

The bits follow several update rules. Two high bits are write-one strobes that clear a companion flag and always read as zero. The stall request, last-packet and transmit-ready bits are set by firmware and cleared by hardware. The early-end, receive-ready and stall-sent flags are set by hardware and cleared by firmware. When a set and a clear reach the same bit in the same cycle, the set takes effect.

Top module: `ep0_ctl_reg`

## Requirements
- R1: After reset, the read-back word and every output are 0.
- R2: Bits 7 and 6 always read as 0. A write with bit 7 = 1 clears the early-end flag (bit 4), and bit 7 = 0 leaves that flag unchanged.
- R3: A write with bit 6 = 1 clears the receive-ready flag (bit 0), and bit 6 = 0 leaves it unchanged.
- R4: A write with bit 5 = 1 sets the stall request (bit 5 and `stall_req`). A stall-sent event clears it. If both arrive in the same cycle, the request stays set.
- R5: A transfer-end event while bit 3 is 0 sets the early-end flag (bit 4). Whenever bit 4 goes from 0 to 1, `fifo_flush` pulses high for one cycle, in the same cycle that bit 4 first reads as 1.
- R6: A write with bit 3 = 1 sets the last-packet flag (bit 3 and `data_end`), and bit 3 = 0 has no effect. A transfer-end event clears the flag. If the write and the event arrive in the same cycle, the flag stays set.
- R7: A stall-sent event sets bit 2. A write with bit 2 = 0 clears bit 2, and a write with bit 2 = 1 leaves it unchanged.
- R8: A write with bit 1 = 1 sets transmit-ready (bit 1 and `tx_ready`). A transmit-done event clears it. If both arrive in the same cycle, transmit-ready stays set.
- R9: A packet-received event sets bit 0. Writing bit 0 has no effect.
- R10: A hardware set and a software clear that reach bit 4, bit 2 or bit 0 in the same cycle leave that bit at 1.
- R11: While `wr_lock` is high, writes have no effect, and hardware events still update the register.
- R12: `irq` is high for one cycle, in the cycle after the update, when bit 4 or bit 0 rose in that update and `int_en` was high in the update cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write data |
| wr_lock | input | 1 | Write protection; when high, writes are dropped |
| int_en | input | 1 | Interrupt enable |
| ev_rx_pkt | input | 1 | Packet received |
| ev_tx_done | input | 1 | Transmit packet sent |
| ev_stall_sent | input | 1 | STALL handshake issued |
| ev_xfer_end | input | 1 | Control transfer terminated |
| rd_data | output | 8 | Register read-back |
| tx_ready | output | 1 | Transmit packet ready for the engine |
| stall_req | output | 1 | Stall request to the engine |
| data_end | output | 1 | Last data packet marker |
| irq | output | 1 | Interrupt pulse |
| fifo_flush | output | 1 | FIFO flush pulse |

## Verification
The main overlap is a firmware write and an endpoint event that reach the same bit in one cycle. Examples are a receive-ready acknowledge arriving together with a new packet, or a transmit-ready set arriving together with a transmit-done. The bench steps through every combination of write data, write enable, lock, interrupt enable and the four events, one per cycle. A separate arithmetic model is built from the requirements and compared against every read-back bit and every output after each step. Directed cases also check the set-over-clear outcome at the ports and confirm that a locked write leaves the register unchanged.

// File: rtl/ep0_ctl_reg.sv
module ep0_ctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_lock,
  input  logic       int_en,
  input  logic       ev_rx_pkt,
  input  logic       ev_tx_done,
  input  logic       ev_stall_sent,
  input  logic       ev_xfer_end,
  output logic [7:0] rd_data,
  output logic       tx_ready,
  output logic       stall_req,
  output logic       data_end,
  output logic       irq,
  output logic       fifo_flush
);

  logic early_q, rx_q, stall_q, last_q, sent_q, tx_q;
  logic early_d, rx_d, stall_d, last_d, sent_d, tx_d;
  logic sw_wr, early_hit;

  assign sw_wr     = wr_en & ~wr_lock;
  assign early_hit = ev_xfer_end & ~last_q;

  assign early_d = early_hit     | (early_q & ~(sw_wr & wr_data[7]));
  assign rx_d    = ev_rx_pkt     | (rx_q    & ~(sw_wr & wr_data[6]));
  assign sent_d  = ev_stall_sent | (sent_q  & ~(sw_wr & ~wr_data[2]));
  assign stall_d = (sw_wr & wr_data[5]) | (stall_q & ~ev_stall_sent);
  assign last_d  = (sw_wr & wr_data[3]) | (last_q  & ~ev_xfer_end);
  assign tx_d    = (sw_wr & wr_data[1]) | (tx_q    & ~ev_tx_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_q    <= 1'b0;
      rx_q       <= 1'b0;
      stall_q    <= 1'b0;
      last_q     <= 1'b0;
      sent_q     <= 1'b0;
      tx_q       <= 1'b0;
      irq        <= 1'b0;
      fifo_flush <= 1'b0;
    end else begin
      early_q    <= early_d;
      rx_q       <= rx_d;
      stall_q    <= stall_d;
      last_q     <= last_d;
      sent_q     <= sent_d;
      tx_q       <= tx_d;
      irq        <= int_en & ((early_d & ~early_q) | (rx_d & ~rx_q));
      fifo_flush <= early_d & ~early_q;
    end
  end

  assign rd_data   = {2'b00, stall_q, early_q, last_q, sent_q, tx_q, rx_q};
  assign tx_ready  = tx_q;
  assign stall_req = stall_q;
  assign data_end  = last_q;

endmodule

module ep0_ctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       wr_lock,
  input logic       int_en,
  input logic       ev_rx_pkt,
  input logic       ev_tx_done,
  input logic       ev_stall_sent,
  input logic       ev_xfer_end,
  input logic [7:0] rd_data,
  input logic       tx_ready,
  input logic       stall_req,
  input logic       data_end,
  input logic       irq,
  input logic       fifo_flush
);

  a_r2_strobes_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00);

  a_r5_flush_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[4]) |-> fifo_flush);

  a_r5_flush_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> rd_data[4]);

  a_r9_rx_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_pkt |=> rd_data[0]);

  a_r7_stall_sent_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall_sent |=> rd_data[2]);

  a_r8_tx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_lock && wr_data[1]) |=> tx_ready);

  a_r11_locked_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && !ev_rx_pkt && !ev_tx_done && !ev_stall_sent && !ev_xfer_end)
      |=> $stable(rd_data));

  a_r12_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(int_en) && ($rose(rd_data[4]) || $rose(rd_data[0]))));

endmodule

bind ep0_ctl_reg ep0_ctl_reg_chk chk_i (.*);

// File: tb/ep0_ctl_reg_tb_top.sv
module ep0_ctl_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_lock = 1'b0, int_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ev_rx_pkt = 1'b0, ev_tx_done = 1'b0, ev_stall_sent = 1'b0, ev_xfer_end = 1'b0;
  logic [7:0] rd_data;
  logic       tx_ready, stall_req, data_end, irq, fifo_flush;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_reg = 8'h00;
  logic       m_irq = 1'b0, m_flush = 1'b0;

  always #4 clk = ~clk;

  ep0_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_lock(wr_lock),
    .int_en(int_en), .ev_rx_pkt(ev_rx_pkt), .ev_tx_done(ev_tx_done),
    .ev_stall_sent(ev_stall_sent), .ev_xfer_end(ev_xfer_end), .rd_data(rd_data),
    .tx_ready(tx_ready), .stall_req(stall_req), .data_end(data_end),
    .irq(irq), .fifo_flush(fifo_flush)
  );

  function automatic string bit_req(input int b);
    case (b)
      7, 6: return "R2";
      5: return "R4";
      4: return "R5";
      3: return "R6";
      2: return "R7";
      1: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    for (int b = 0; b < 8; b++) chk(bit_req(b), {7'd0, rd_data[b]}, {7'd0, m_reg[b]});
    chk("R8", {7'd0, tx_ready}, {7'd0, m_reg[1]});
    chk("R4", {7'd0, stall_req}, {7'd0, m_reg[5]});
    chk("R6", {7'd0, data_end}, {7'd0, m_reg[3]});
    chk("R12", {7'd0, irq}, {7'd0, m_irq});
    chk("R5", {7'd0, fifo_flush}, {7'd0, m_flush});
  endtask

  // one cycle: drive at negedge, advance the model, compare at the next negedge
  task automatic cyc(input logic we, input logic lk, input logic ie, input logic [7:0] d,
                     input logic erx, input logic etx, input logic est, input logic eend);
    logic w, se, rx, st, de, ss, tx;
    wr_en = we; wr_lock = lk; int_en = ie; wr_data = d;
    ev_rx_pkt = erx; ev_tx_done = etx; ev_stall_sent = est; ev_xfer_end = eend;
    w  = we && !lk;
    se = (eend && !m_reg[3]) ? 1'b1 : (w && d[7]) ? 1'b0 : m_reg[4];
    rx = erx ? 1'b1 : (w && d[6]) ? 1'b0 : m_reg[0];
    ss = est ? 1'b1 : (w && !d[2]) ? 1'b0 : m_reg[2];
    st = (w && d[5]) ? 1'b1 : est ? 1'b0 : m_reg[5];
    de = (w && d[3]) ? 1'b1 : eend ? 1'b0 : m_reg[3];
    tx = (w && d[1]) ? 1'b1 : etx ? 1'b0 : m_reg[1];
    m_flush = se && !m_reg[4];
    m_irq = ie && ((se && !m_reg[4]) || (rx && !m_reg[0]));
    m_reg = {2'b00, st, se, de, ss, tx, rx};
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", rd_data, 8'h00);
    chk("R1", {3'd0, tx_ready, stall_req, data_end, irq, fifo_flush}, 8'h00);

    // R11: locked write leaves the word at zero
    cyc(1, 1, 1, 8'h2A, 0, 0, 0, 0);
    chk("R11", rd_data, 8'h00);
    // R9 + R12: packet arrives, interrupt pulses, writing bit0 does nothing
    cyc(0, 0, 1, 8'h00, 1, 0, 0, 0);
    chk("R12", {7'd0, irq}, 8'h01);
    cyc(1, 0, 1, 8'h04, 0, 0, 0, 0);
    chk("R9", {7'd0, rd_data[0]}, 8'h01);
    // R10: acknowledge collides with a new packet; the flag stays set
    cyc(1, 0, 1, 8'h44, 1, 0, 0, 0);
    chk("R10", {7'd0, rd_data[0]}, 8'h01);
    // R3: plain acknowledge clears
    cyc(1, 0, 1, 8'h44, 0, 0, 0, 0);
    chk("R3", {7'd0, rd_data[0]}, 8'h00);
    // R5: early end raises flag and flush; R2 strobe clears it
    cyc(0, 0, 0, 8'h00, 0, 0, 0, 1);
    chk("R5", {6'd0, rd_data[4], fifo_flush}, 8'h03);
    cyc(1, 0, 0, 8'h84, 0, 0, 0, 0);
    chk("R2", rd_data, 8'h00);

    // sweep over every input combination
    for (int i = 0; i < 32768; i++) begin
      logic [14:0] v;
      v = 15'(i);
      cyc(v[8], v[9], v[10], v[7:0], v[11], v[12], v[13], v[14]);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule